// File: doc/BRIEF.md
# Shared Functional Unit Request Arbiter

This block lets several processing engines share one functional unit. Each engine offers a request on its own valid/ready port. The request carries an argument payload and the ID of the engine thread that issued it. In each cycle the arbiter picks one requesting engine in rotating order and forwards that engine's argument to the functional unit. It also sends a tag that names the source engine and the thread. The functional unit accepts at most one request per cycle, and its ready signal gates every grant.

Replies return from the functional unit carrying the same tag, with any latency and in any order. The arbiter uses the engine field of the tag to decide which engine gets the reply. It registers the reply data and thread ID into that engine's reply port and raises that engine's reply valid for a single cycle. Engines that do not own the reply see nothing, so a slow reply for one engine never holds up the others.

Top module: `fu_arbiter`

## Requirements
- R1: `fuReqValid` is high exactly when at least one engine holds `reqValid` high, and `fuReqArg` carries the argument of the engine being granted.
- R2: At most one bit of `reqReady` is high in any cycle, and a high bit always belongs to an engine whose `reqValid` is high.
- R3: While `fuReqReady` is low, every bit of `reqReady` is low and the round-robin position does not move.
- R4: Grants rotate. After engine g is accepted, the next grant goes to the first requesting engine after g in cyclic order g+1, g+2, ... After reset, engine 0 has the highest priority.
- R5: `fuReqTag` is {engine index, thread ID}. The engine index sits in the upper `SRC_W` bits and the requesting engine's `reqThread` sits in the lower `TID_W` bits.
- R6: A reply with tag {e, t} arriving in cycle c appears in cycle c+1 on engine e only. `rspValid[e]` is high for that one cycle, engine e's `rspThread` slice equals t, and its `rspData` slice equals the reply data. Every other engine's `rspValid` stays low.
- R7: Reply routing depends only on the returned tag. Replies that arrive back to back, in an order different from issue, or after any latency each reach their own engine.
- R8: An engine that keeps its request raised is granted within N accepted grants.
- R9: After reset, `rspValid` is all zero, and `reqReady` is zero while no engine requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | N | Request valid, one bit per engine |
| reqReady | output | N | Request accepted this cycle, one bit per engine |
| reqArg | input | N*ARG_W | Request arguments; engine i in slice i |
| reqThread | input | N*TID_W | Issuing thread ID; engine i in slice i |
| fuReqValid | output | 1 | Request valid toward the functional unit |
| fuReqReady | input | 1 | Functional unit can accept a request |
| fuReqArg | output | ARG_W | Granted argument |
| fuReqTag | output | SRC_W+TID_W | {engine index, thread ID} |
| fuRspValid | input | 1 | Reply valid from the functional unit |
| fuRspTag | input | SRC_W+TID_W | Tag returned with the reply |
| fuRspData | input | RSP_W | Reply data |
| rspValid | output | N | One-cycle reply strobe per engine |
| rspThread | output | N*TID_W | Thread ID of the reply; engine i in slice i |
| rspData | output | N*RSP_W | Reply data; engine i in slice i |

## Verification
The grant logic is swept over all sixteen request masks of a four-engine configuration. The sweep runs twice, with the functional unit's ready toggled in a fixed pattern, so that stalled cycles can be told apart from rotation updates. A bench model of the rotating pointer predicts every grant. Reply routing is driven with all sixteen tags, first in forward order, then reversed, then back to back. This separates decoding by engine from decoding by thread and shows that each strobe lasts exactly one cycle. A final run connects a three-cycle delay-line stand-in unit with every engine requesting. It checks the steady rotation and checks that each transformed reply returns to the engine and thread that issued it.

// File: rtl/fu_arb_pkg.sv
package fu_arb_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic fire;     // a request is handed to the unit this cycle
    logic rspLoad;  // a reply is arriving this cycle
  } arbStrobeT;

  function automatic int srcWidth(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fu_arb_ctrl.sv
module fu_arb_ctrl
  import fu_arb_pkg::*;
#(
  parameter int N = 4,
  parameter int SRC_W = srcWidth(N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     reqValid,
  input  logic             fuReqReady,
  input  logic             fuRspValid,
  input  logic [SRC_W-1:0] fuRspSrc,
  output logic             anyReq,
  output logic [SRC_W-1:0] grantIdx,
  output logic [N-1:0]     reqReady,
  output logic [N-1:0]     rspSel,
  output arbStrobeT        strobe
);
  localparam logic [SRC_W-1:0] LastIdx = SRC_W'(N - 1);

  logic [SRC_W-1:0] lastGrant;
  logic             found;

  // Scan engines in cyclic order starting after the last accepted one
  always_comb begin
    found    = 1'b0;
    grantIdx = '0;
    for (int k = 1; k <= N; k++) begin
      int cand;
      cand = (int'(lastGrant) + k) % N;
      if (!found && reqValid[cand]) begin
        found    = 1'b1;
        grantIdx = SRC_W'(cand);
      end
    end
  end

  assign anyReq         = |reqValid;
  assign strobe.fire    = found && fuReqReady;
  assign strobe.rspLoad = fuRspValid;

  for (genvar i = 0; i < N; i++) begin : g_sel
    assign reqReady[i] = strobe.fire && (grantIdx == SRC_W'(i));
    assign rspSel[i]   = fuRspValid && (fuRspSrc == SRC_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) lastGrant <= LastIdx;
    else if (strobe.fire) lastGrant <= grantIdx;
  end
endmodule

// File: rtl/fu_arb_dpath.sv
module fu_arb_dpath
  import fu_arb_pkg::*;
#(
  parameter int N = 4,
  parameter int ARG_W = 16,
  parameter int RSP_W = 16,
  parameter int TID_W = 2,
  parameter int SRC_W = srcWidth(N),
  parameter int TAG_W = SRC_W + TID_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  arbStrobeT          strobe,
  input  logic [SRC_W-1:0]   grantIdx,
  input  logic [N-1:0]       rspSel,
  input  logic [N*ARG_W-1:0] reqArg,
  input  logic [N*TID_W-1:0] reqThread,
  output logic [ARG_W-1:0]   fuReqArg,
  output logic [TAG_W-1:0]   fuReqTag,
  input  logic [TAG_W-1:0]   fuRspTag,
  input  logic [RSP_W-1:0]   fuRspData,
  output logic [N-1:0]       rspValid,
  output logic [N*TID_W-1:0] rspThread,
  output logic [N*RSP_W-1:0] rspData
);
  logic [TID_W-1:0] grantThread;

  assign fuReqArg    = reqArg[grantIdx * ARG_W +: ARG_W];
  assign grantThread = reqThread[grantIdx * TID_W +: TID_W];
  assign fuReqTag    = {grantIdx, grantThread};

  for (genvar i = 0; i < N; i++) begin : g_rsp
    logic             validQ;
    logic [TID_W-1:0] threadQ;
    logic [RSP_W-1:0] dataQ;

    always_ff @(posedge clk) begin
      if (!rstN) validQ <= 1'b0;
      else       validQ <= strobe.rspLoad && rspSel[i];
    end

    always_ff @(posedge clk) begin
      if (strobe.rspLoad && rspSel[i]) begin
        threadQ <= fuRspTag[TID_W-1:0];
        dataQ   <= fuRspData;
      end
    end

    assign rspValid[i]                    = validQ;
    assign rspThread[i*TID_W +: TID_W]    = threadQ;
    assign rspData[i*RSP_W +: RSP_W]      = dataQ;
  end
endmodule

// File: rtl/fu_arbiter.sv
module fu_arbiter
  import fu_arb_pkg::*;
#(
  parameter int N = 4,
  parameter int ARG_W = 16,
  parameter int RSP_W = 16,
  parameter int TID_W = 2,
  parameter int SRC_W = srcWidth(N),
  parameter int TAG_W = SRC_W + TID_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N-1:0]       reqValid,
  output logic [N-1:0]       reqReady,
  input  logic [N*ARG_W-1:0] reqArg,
  input  logic [N*TID_W-1:0] reqThread,
  output logic               fuReqValid,
  input  logic               fuReqReady,
  output logic [ARG_W-1:0]   fuReqArg,
  output logic [TAG_W-1:0]   fuReqTag,
  input  logic               fuRspValid,
  input  logic [TAG_W-1:0]   fuRspTag,
  input  logic [RSP_W-1:0]   fuRspData,
  output logic [N-1:0]       rspValid,
  output logic [N*TID_W-1:0] rspThread,
  output logic [N*RSP_W-1:0] rspData
);
  arbStrobeT        strobe;
  logic [SRC_W-1:0] grantIdx;
  logic [N-1:0]     rspSel;

  fu_arb_ctrl #(.N(N), .SRC_W(SRC_W)) ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .fuReqReady(fuReqReady),
    .fuRspValid(fuRspValid), .fuRspSrc(fuRspTag[TAG_W-1:TID_W]),
    .anyReq(fuReqValid), .grantIdx(grantIdx), .reqReady(reqReady),
    .rspSel(rspSel), .strobe(strobe)
  );

  fu_arb_dpath #(.N(N), .ARG_W(ARG_W), .RSP_W(RSP_W), .TID_W(TID_W),
                 .SRC_W(SRC_W), .TAG_W(TAG_W)) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .grantIdx(grantIdx),
    .rspSel(rspSel), .reqArg(reqArg), .reqThread(reqThread),
    .fuReqArg(fuReqArg), .fuReqTag(fuReqTag), .fuRspTag(fuRspTag),
    .fuRspData(fuRspData), .rspValid(rspValid), .rspThread(rspThread),
    .rspData(rspData)
  );
endmodule

// File: rtl/fu_arbiter_chk.sv
module fu_arbiter_chk #(
  parameter int N = 4,
  parameter int RSP_W = 16,
  parameter int TID_W = 2,
  parameter int SRC_W = 2,
  parameter int TAG_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [N-1:0]       reqValid,
  input logic [N-1:0]       reqReady,
  input logic               fuReqValid,
  input logic               fuReqReady,
  input logic [TAG_W-1:0]   fuReqTag,
  input logic               fuRspValid,
  input logic [TAG_W-1:0]   fuRspTag,
  input logic [RSP_W-1:0]   fuRspData,
  input logic [N-1:0]       rspValid,
  input logic [N*RSP_W-1:0] rspData
);
  assert_fu_valid_R1: assert property (@(posedge clk) disable iff (!rstN)
    fuReqValid == (|reqValid));

  assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqReady) && ((reqReady & ~reqValid) == '0));

  assert_stall_blocks_R3: assert property (@(posedge clk) disable iff (!rstN)
    !fuReqReady |-> (reqReady == '0));

  assert_no_stray_rsp_R6: assert property (@(posedge clk) disable iff (!rstN)
    !fuRspValid |=> (rspValid == '0));

  assert_rsp_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(rspValid) <= 1);

  for (genvar i = 0; i < N; i++) begin : g_eng
    assert_tag_source_R5: assert property (@(posedge clk) disable iff (!rstN)
      reqReady[i] |-> (fuReqTag[TAG_W-1:TID_W] == SRC_W'(i)));

    assert_rsp_route_R7: assert property (@(posedge clk) disable iff (!rstN)
      (fuRspValid && fuRspTag[TAG_W-1:TID_W] == SRC_W'(i)) |=>
        (rspValid[i] && rspData[i*RSP_W +: RSP_W] == $past(fuRspData)));
  end
endmodule

bind fu_arbiter fu_arbiter_chk #(.N(N), .RSP_W(RSP_W), .TID_W(TID_W),
                                 .SRC_W(SRC_W), .TAG_W(TAG_W)) chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .fuReqValid(fuReqValid), .fuReqReady(fuReqReady), .fuReqTag(fuReqTag),
  .fuRspValid(fuRspValid), .fuRspTag(fuRspTag), .fuRspData(fuRspData),
  .rspValid(rspValid), .rspData(rspData)
);

// File: tb/fu_arbiter_test.sv
module fu_arbiter_test;
  localparam int N = 4, ARG_W = 16, RSP_W = 16, TID_W = 2, SRC_W = 2;
  localparam int TAG_W = SRC_W + TID_W;
  localparam int LAT = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic [N-1:0] reqValid = '0, reqReady, rspValid;
  logic [N*ARG_W-1:0] reqArg = '0;
  logic [N*TID_W-1:0] reqThread = '0, rspThread;
  logic fuReqValid, fuReqReady = 1'b0, fuRspValid = 1'b0;
  logic [ARG_W-1:0] fuReqArg;
  logic [TAG_W-1:0] fuReqTag, fuRspTag = '0;
  logic [RSP_W-1:0] fuRspData = '0;
  logic [N*RSP_W-1:0] rspData;

  int checks = 0, failures = 0;
  int lastModel = N - 1;

  always #5 clk = ~clk;

  fu_arbiter uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqArg(reqArg), .reqThread(reqThread), .fuReqValid(fuReqValid),
    .fuReqReady(fuReqReady), .fuReqArg(fuReqArg), .fuReqTag(fuReqTag),
    .fuRspValid(fuRspValid), .fuRspTag(fuRspTag), .fuRspData(fuRspData),
    .rspValid(rspValid), .rspThread(rspThread), .rspData(rspData)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic int expGrant(input int last, input logic [N-1:0] m);
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (last + k) % N;
      if (m[idx]) return idx;
    end
    return -1;
  endfunction

  task automatic setReqs(input logic [N-1:0] m, input int salt);
    reqValid = m;
    for (int i = 0; i < N; i++) begin
      reqArg[i*ARG_W +: ARG_W]    = {4'(i), 12'(salt)};
      reqThread[i*TID_W +: TID_W] = TID_W'(i + salt);
    end
  endtask

  // Checks the combinational request side against the pointer model
  task automatic checkGrant(input logic [N-1:0] m, input logic rdy, input int salt);
    int g;
    g = expGrant(lastModel, m);
    check("R1 fuReqValid", 32'(fuReqValid), 32'(m != 0));
    if (rdy && g >= 0) begin
      check("R4 R2 reqReady", 32'(reqReady), 32'(1 << g));
      check("R1 fuReqArg", 32'(fuReqArg), {16'h0, 4'(g), 12'(salt)});
      check("R5 fuReqTag", 32'(fuReqTag), 32'({2'(g), 2'(g + salt)}));
    end else begin
      check("R3 reqReady idle", 32'(reqReady), 32'h0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    check("R9 rspValid reset", 32'(rspValid), 32'h0);
    check("R9 reqReady reset", 32'(reqReady), 32'h0);

    // Grant sweep: all masks twice, ready stalls in a fixed pattern (R3, R4, R8)
    for (int pass = 0; pass < 2; pass++) begin
      for (int m = 0; m < 16; m++) begin
        logic rdy;
        int g;
        @(negedge clk);
        rdy = ((m + pass) % 3) != 0;
        fuReqReady = rdy;
        setReqs(4'(m), m + pass * 16);
        #2;
        checkGrant(4'(m), rdy, m + pass * 16);
        g = expGrant(lastModel, 4'(m));
        if (rdy && g >= 0) lastModel = g;
      end
    end
    @(negedge clk);
    setReqs('0, 0);
    fuReqReady = 1'b0;

    // Reply routing, forward then reverse tag order (R6, R7)
    for (int dir = 0; dir < 2; dir++) begin
      for (int n = 0; n < 16; n++) begin
        int tag, e, t;
        tag = (dir == 0) ? n : 15 - n;
        e = tag >> 2;
        t = tag & 3;
        @(negedge clk);
        fuRspValid = 1'b1;
        fuRspTag   = 4'(tag);
        fuRspData  = 16'hA000 + 16'(dir * 256 + tag);
        @(negedge clk);
        fuRspValid = 1'b0;
        check("R6 rspValid route", 32'(rspValid), 32'(1 << e));
        check("R6 rspThread", 32'(rspThread[e*TID_W +: TID_W]), 32'(t));
        check("R7 rspData", 32'(rspData[e*RSP_W +: RSP_W]), 32'(16'hA000 + 16'(dir * 256 + tag)));
        @(negedge clk);
        check("R6 one cycle strobe", 32'(rspValid), 32'h0);
      end
    end

    // Back-to-back replies to different engines (R7)
    @(negedge clk);
    fuRspValid = 1'b1; fuRspTag = 4'b11_01; fuRspData = 16'h1234;
    @(negedge clk);
    check("R7 back-to-back first", 32'(rspValid), 32'h8);
    fuRspTag = 4'b00_10; fuRspData = 16'h5678;
    @(negedge clk);
    fuRspValid = 1'b0;
    check("R7 back-to-back second", 32'(rspValid), 32'h1);
    check("R7 back-to-back data", 32'(rspData[0 +: RSP_W]), 32'h5678);
    check("R7 earlier data kept", 32'(rspData[3*RSP_W +: RSP_W]), 32'h1234);

    // Delay-line stand-in unit, all engines requesting (R4, R7, R8)
    begin
      logic [TAG_W-1:0] issTag [64];
      logic [RSP_W-1:0] issData[64];
      logic pending = 1'b0;
      logic [TAG_W-1:0] pendTag = '0;
      logic [RSP_W-1:0] pendData = '0;
      for (int c = 0; c < 32; c++) begin
        int e;
        @(negedge clk);
        if (pending) begin
          e = int'(pendTag[3:2]);
          check("R7 pipe route", 32'(rspValid), 32'(1 << e));
          check("R7 pipe thread", 32'(rspThread[e*TID_W +: TID_W]), 32'(pendTag[1:0]));
          check("R7 pipe data", 32'(rspData[e*RSP_W +: RSP_W]), 32'(pendData));
        end
        pending = 1'b0;
        fuReqReady = 1'b1;
        setReqs((c < 24) ? 4'hF : 4'h0, c + 40);
        if (c >= LAT && c - LAT < 24) begin
          fuRspValid = 1'b1;
          fuRspTag   = issTag[c - LAT];
          fuRspData  = issData[c - LAT];
          pending    = 1'b1;
          pendTag    = issTag[c - LAT];
          pendData   = issData[c - LAT];
        end else begin
          fuRspValid = 1'b0;
        end
        #2;
        if (c < 24) begin
          int g;
          g = (lastModel + 1) % N;
          check("R8 rotation", 32'(reqReady), 32'(1 << g));
          issTag[c]  = fuReqTag;
          issData[c] = fuReqArg ^ 16'h5A5A;
          check("R5 pipe tag", 32'(fuReqTag), 32'({2'(g), 2'(g + c + 40)}));
          lastModel = g;
        end
      end
    end
    @(negedge clk);
    fuRspValid = 1'b0;
    setReqs('0, 0);
    @(negedge clk);
    check("R6 quiet after drain", 32'(rspValid), 32'h0);
    finishRun();
  end
endmodule